// File: doc/BRIEF.md
# Motion Event Detector (activity, inactivity, free-fall)

This block watches the per-axis acceleration magnitudes of a three-axis sensor and reports three kinds of motion events. Each event appears as a one-cycle pulse. Activity means an enabled axis magnitude rises above a threshold. Free-fall means all three axes stay below a low threshold for a programmed dwell. Inactivity means the enabled axes stay quiet for a programmed number of seconds.

Two sample streams enter the block. Each carries three magnitudes and a valid strobe. The unfiltered stream feeds the activity and free-fall detectors. The filtered output-data stream feeds only the inactivity detector. The dwell times are counted in ticks of a time unit supplied from outside: `ffTick` is the free-fall time unit (nominally 5 ms) and `secTick` is the inactivity unit (1 s). Thresholds are 8-bit unsigned codes in the same units as the magnitudes (nominally 62.5 mg per LSB). Magnitudes are packed with axis X in bits [MAG_W-1:0], Y above it and Z at the top.

Each event is produced once per episode and then waits for the condition to break. A register captures each sample's comparison flags. A second register stage holds the episode state, and the pulse register follows it.

Top module: `motion_event_detector`

## Requirements
- R1: A valid unfiltered sample in which some enabled axis has a magnitude strictly greater than `actThresh` produces an `actPulse`. The pulse is high in the cycle after the second rising edge following the edge that captures the sample. A magnitude equal to the threshold does not count.
- R2: Axis enable bit i (X=0, Y=1, Z=2) of `actAxisEn` / `inactAxisEn` includes that axis in the activity / inactivity comparison. A disabled axis is ignored, whatever its magnitude.
- R3: `ffPulse` fires once all three unfiltered magnitudes have been strictly below `ffThresh` on a sample, and then `ffTime` further `ffTick` pulses have arrived with no breaking sample. The pulse comes one cycle after the last of those ticks. With `ffTime` = 0 it fires on the below-threshold sample itself, with the R1 latency.
- R4: An unfiltered sample with any axis magnitude at or above `ffThresh` clears the free-fall dwell count. Counting restarts from zero at the next all-below sample.
- R5: Inactivity looks only at filtered samples. Unfiltered samples never change it, and filtered samples never cause activity or free-fall events.
- R6: `inactPulse` fires after a filtered sample in which every enabled axis is strictly below `inactThresh`, followed by `inactTime` `secTick` pulses with no breaking filtered sample. With `inactTime` = 0 it fires on that quiet sample itself, with the R1 latency.
- R7: Each event pulses at most once per episode. It fires again only after a sample of its own stream has broken the condition and the condition has then been met anew.
- R8: Every event pulse lasts exactly one clock cycle.
- R9: While `rstN` is low and right after its release, all three pulses are low. All detectors are idle and armed.
- R10: Inactivity never fires before a quiet filtered sample has arrived, however many `secTick` pulses occur. It never fires while `inactAxisEn` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rawValid | input | 1 | Unfiltered sample strobe |
| rawMag | input | 3*MAG_W | Unfiltered magnitudes {Z,Y,X} |
| filtValid | input | 1 | Filtered sample strobe |
| filtMag | input | 3*MAG_W | Filtered magnitudes {Z,Y,X} |
| ffTick | input | 1 | Free-fall time-unit tick |
| secTick | input | 1 | One-second tick |
| actThresh | input | THR_W | Activity threshold |
| inactThresh | input | THR_W | Inactivity threshold |
| ffThresh | input | THR_W | Free-fall threshold |
| ffTime | input | TIME_W | Free-fall dwell in ffTick units |
| inactTime | input | TIME_W | Inactivity dwell in secTick units |
| actAxisEn | input | 3 | Activity axis enables |
| inactAxisEn | input | 3 | Inactivity axis enables |
| actPulse | output | 1 | Activity event pulse |
| ffPulse | output | 1 | Free-fall event pulse |
| inactPulse | output | 1 | Inactivity event pulse |

## Verification
A pulse caused by a sample is due two rising edges after the edge that captures the sample. A pulse completed by a tick is due one edge after the edge that captures that tick. The bench drives every input just after a falling edge and counts pulses on falling edges. After each stimulus it waits long enough for the due pulse, then compares how much each pulse count grew. The exact-latency tests instead sample the pulse on the falling edges just before, at and after the due cycle. That shows both where the pulse appears and that it lasts one cycle.

// File: rtl/mev_pkg.sv
package mev_pkg;
  localparam int NUM_AXES   = 3;
  localparam int NUM_EVENTS = 3;
  localparam int EV_ACT     = 0;
  localparam int EV_FF      = 1;
  localparam int EV_INACT   = 2;

  typedef struct packed {
    logic rawValid;
    logic filtValid;
    logic actHit;
    logic ffLow;
    logic inactLow;
  } evStrobe_t;
endpackage

// File: rtl/mev_datapath.sv
module mev_datapath
  import mev_pkg::*;
#(
  parameter int MAG_W = 8,
  parameter int THR_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      rawValid,
  input  logic [NUM_AXES*MAG_W-1:0] rawMag,
  input  logic                      filtValid,
  input  logic [NUM_AXES*MAG_W-1:0] filtMag,
  input  logic [THR_W-1:0]          actThresh,
  input  logic [THR_W-1:0]          inactThresh,
  input  logic [THR_W-1:0]          ffThresh,
  input  logic [NUM_AXES-1:0]       actAxisEn,
  input  logic [NUM_AXES-1:0]       inactAxisEn,
  output evStrobe_t                 strobe
);
  logic [MAG_W-1:0] actLim, inactLim, ffLim;
  logic [NUM_AXES-1:0] overAct, underFf, underInact;

  assign actLim   = MAG_W'(actThresh);
  assign inactLim = MAG_W'(inactThresh);
  assign ffLim    = MAG_W'(ffThresh);

  for (genvar i = 0; i < NUM_AXES; i++) begin : gAxis
    logic [MAG_W-1:0] rawAxis, filtAxis;
    assign rawAxis       = rawMag[i*MAG_W +: MAG_W];
    assign filtAxis      = filtMag[i*MAG_W +: MAG_W];
    assign overAct[i]    = actAxisEn[i] && (rawAxis > actLim);
    assign underFf[i]    = rawAxis < ffLim;
    assign underInact[i] = !inactAxisEn[i] || (filtAxis < inactLim);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      strobe <= '0;
    end else begin
      strobe.rawValid  <= rawValid;
      strobe.filtValid <= filtValid;
      strobe.actHit    <= rawValid && (|overAct);
      strobe.ffLow     <= rawValid && (&underFf);
      strobe.inactLow  <= filtValid && (&underInact) && (|inactAxisEn);
    end
  end

  // R2: an activity hit needs at least one enabled axis
  p_act_needs_enable_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.actHit |-> $past(|actAxisEn));
  // R5: the inactivity flag only comes from the filtered stream
  p_inact_from_filt_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.inactLow |-> $past(filtValid));
  // R5: the free-fall flag only comes from the unfiltered stream
  p_ff_from_raw_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ffLow |-> $past(rawValid));
endmodule

// File: rtl/mev_dwell_timer.sv
module mev_dwell_timer #(
  parameter int TIME_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic              qualifies,
  input  logic              tick,
  input  logic [TIME_W-1:0] limit,
  output logic              firePulse
);
  localparam logic [TIME_W-1:0] CNT_MAX = '1;

  logic              active, armed;
  logic [TIME_W-1:0] cnt;
  logic              breakNow, fireNow;

  assign breakNow = sampleValid && !qualifies;
  assign fireNow  = active && armed && (cnt >= limit) && !breakNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active    <= 1'b0;
      armed     <= 1'b1;
      cnt       <= '0;
      firePulse <= 1'b0;
    end else begin
      firePulse <= fireNow;
      if (breakNow) begin
        active <= 1'b0;
        armed  <= 1'b1;
        cnt    <= '0;
      end else begin
        if (sampleValid && qualifies && !active) begin
          active <= 1'b1;
          cnt    <= '0;
        end else if (active && tick && cnt != CNT_MAX) begin
          cnt <= cnt + 1'b1;
        end
        if (fireNow) armed <= 1'b0;
      end
    end
  end

  // R8: pulses are one cycle wide
  p_single_cycle_r8: assert property (@(posedge clk) disable iff (!rstN)
    firePulse |=> !firePulse);
  // R3: a pulse only follows a dwell count that reached the limit
  p_limit_reached_r3: assert property (@(posedge clk) disable iff (!rstN)
    firePulse |-> ($past(cnt) >= $past(limit)));
  // R10: an episode only starts on a qualifying sample
  p_episode_needs_sample_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(active) |-> $past(sampleValid && qualifies));
  // R4: a breaking sample leaves the count cleared
  p_break_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    breakNow |=> (cnt == '0) && !firePulse);
endmodule

// File: rtl/mev_control.sv
module mev_control
  import mev_pkg::*;
#(
  parameter int TIME_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  evStrobe_t         strobe,
  input  logic              ffTick,
  input  logic              secTick,
  input  logic [TIME_W-1:0] ffTime,
  input  logic [TIME_W-1:0] inactTime,
  output logic              actPulse,
  output logic              ffPulse,
  output logic              inactPulse
);
  logic              evValid [NUM_EVENTS];
  logic              evQual  [NUM_EVENTS];
  logic              evTick  [NUM_EVENTS];
  logic [TIME_W-1:0] evLimit [NUM_EVENTS];
  logic              evFire  [NUM_EVENTS];

  always_comb begin
    evValid[EV_ACT]   = strobe.rawValid;
    evQual[EV_ACT]    = strobe.actHit;
    evTick[EV_ACT]    = 1'b0;
    evLimit[EV_ACT]   = '0;
    evValid[EV_FF]    = strobe.rawValid;
    evQual[EV_FF]     = strobe.ffLow;
    evTick[EV_FF]     = ffTick;
    evLimit[EV_FF]    = ffTime;
    evValid[EV_INACT] = strobe.filtValid;
    evQual[EV_INACT]  = strobe.inactLow;
    evTick[EV_INACT]  = secTick;
    evLimit[EV_INACT] = inactTime;
  end

  for (genvar e = 0; e < NUM_EVENTS; e++) begin : gEvent
    mev_dwell_timer #(.TIME_W(TIME_W)) uTimer (
      .clk        (clk),
      .rstN       (rstN),
      .sampleValid(evValid[e]),
      .qualifies  (evQual[e]),
      .tick       (evTick[e]),
      .limit      (evLimit[e]),
      .firePulse  (evFire[e])
    );
  end

  assign actPulse   = evFire[EV_ACT];
  assign ffPulse    = evFire[EV_FF];
  assign inactPulse = evFire[EV_INACT];

  // R7: activity fires only on a strobe that saw a hit two edges earlier
  p_act_from_hit_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(actPulse) |-> $past(strobe.actHit, 2));
endmodule

// File: rtl/motion_event_detector.sv
module motion_event_detector
  import mev_pkg::*;
#(
  parameter int MAG_W  = 8,
  parameter int THR_W  = 8,
  parameter int TIME_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  rawValid,
  input  logic [3*MAG_W-1:0]    rawMag,
  input  logic                  filtValid,
  input  logic [3*MAG_W-1:0]    filtMag,
  input  logic                  ffTick,
  input  logic                  secTick,
  input  logic [THR_W-1:0]      actThresh,
  input  logic [THR_W-1:0]      inactThresh,
  input  logic [THR_W-1:0]      ffThresh,
  input  logic [TIME_W-1:0]     ffTime,
  input  logic [TIME_W-1:0]     inactTime,
  input  logic [2:0]            actAxisEn,
  input  logic [2:0]            inactAxisEn,
  output logic                  actPulse,
  output logic                  ffPulse,
  output logic                  inactPulse
);
  evStrobe_t strobe;

  mev_datapath #(.MAG_W(MAG_W), .THR_W(THR_W)) uDatapath (
    .clk        (clk),
    .rstN       (rstN),
    .rawValid   (rawValid),
    .rawMag     (rawMag),
    .filtValid  (filtValid),
    .filtMag    (filtMag),
    .actThresh  (actThresh),
    .inactThresh(inactThresh),
    .ffThresh   (ffThresh),
    .actAxisEn  (actAxisEn),
    .inactAxisEn(inactAxisEn),
    .strobe     (strobe)
  );

  mev_control #(.TIME_W(TIME_W)) uControl (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .ffTick    (ffTick),
    .secTick   (secTick),
    .ffTime    (ffTime),
    .inactTime (inactTime),
    .actPulse  (actPulse),
    .ffPulse   (ffPulse),
    .inactPulse(inactPulse)
  );
endmodule

// File: tb/motion_event_detector_test.sv
`timescale 1ns/1ps
module motion_event_detector_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rawValid = 1'b0, filtValid = 1'b0;
  logic [23:0] rawMag = '0, filtMag = '0;
  logic        ffTick = 1'b0, secTick = 1'b0;
  logic [7:0]  actThresh = 8'd100, inactThresh = 8'd20, ffThresh = 8'd10;
  logic [7:0]  ffTime = 8'd0, inactTime = 8'd0;
  logic [2:0]  actAxisEn = 3'b111, inactAxisEn = 3'b111;
  logic        actPulse, ffPulse, inactPulse;

  int nAct = 0, nFf = 0, nInact = 0;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  motion_event_detector uut (
    .clk(clk), .rstN(rstN), .rawValid(rawValid), .rawMag(rawMag),
    .filtValid(filtValid), .filtMag(filtMag), .ffTick(ffTick), .secTick(secTick),
    .actThresh(actThresh), .inactThresh(inactThresh), .ffThresh(ffThresh),
    .ffTime(ffTime), .inactTime(inactTime), .actAxisEn(actAxisEn),
    .inactAxisEn(inactAxisEn), .actPulse(actPulse), .ffPulse(ffPulse),
    .inactPulse(inactPulse)
  );

  always @(negedge clk) begin
    if (actPulse)   nAct++;
    if (ffPulse)    nFf++;
    if (inactPulse) nInact++;
  end

  typedef struct packed {
    logic [7:0] x, y, z;
    logic [2:0] en;
    logic       expAct;
    logic       expFf;
  } vec_t;

  // ffThresh=10, actThresh=100, ffTime=0; en bit0 = X
  localparam vec_t VEC [13] = '{
    '{8'd50,  8'd50,  8'd50,  3'b111, 1'b0, 1'b0},
    '{8'd120, 8'd0,   8'd0,   3'b111, 1'b1, 1'b0},
    '{8'd130, 8'd0,   8'd0,   3'b111, 1'b0, 1'b0},
    '{8'd5,   8'd5,   8'd5,   3'b111, 1'b0, 1'b1},
    '{8'd3,   8'd3,   8'd3,   3'b111, 1'b0, 1'b0},
    '{8'd100, 8'd100, 8'd100, 3'b111, 1'b0, 1'b0},
    '{8'd101, 8'd0,   8'd0,   3'b111, 1'b1, 1'b0},
    '{8'd9,   8'd9,   8'd10,  3'b111, 1'b0, 1'b0},
    '{8'd9,   8'd9,   8'd9,   3'b111, 1'b0, 1'b1},
    '{8'd0,   8'd0,   8'd200, 3'b111, 1'b1, 1'b0},
    '{8'd0,   8'd0,   8'd0,   3'b111, 1'b0, 1'b1},
    '{8'd200, 8'd0,   8'd0,   3'b110, 1'b0, 1'b0},
    '{8'd0,   8'd200, 8'd0,   3'b110, 1'b1, 1'b0}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic raw(input logic [7:0] x, y, z);
    rawMag = {z, y, x}; rawValid = 1'b1; step(1); rawValid = 1'b0; step(4);
  endtask

  task automatic filt(input logic [7:0] x, y, z);
    filtMag = {z, y, x}; filtValid = 1'b1; step(1); filtValid = 1'b0; step(4);
  endtask

  task automatic tickFf();
    ffTick = 1'b1; step(1); ffTick = 1'b0; step(2);
  endtask

  task automatic tickSec();
    secTick = 1'b1; step(1); secTick = 1'b0; step(2);
  endtask

  task automatic doReset();
    rstN = 1'b0; step(3);
    chk("R9 reset act", int'(actPulse), 0);
    chk("R9 reset ff", int'(ffPulse), 0);
    chk("R9 reset inact", int'(inactPulse), 0);
    rstN = 1'b1; step(2);
  endtask

  initial begin
    int a0, f0, i0;
    doReset();
    chk("R9 after release", int'(actPulse | ffPulse | inactPulse), 0);

    // table: R1 R2 R3 R4 R7 with ffTime = 0
    foreach (VEC[k]) begin
      a0 = nAct; f0 = nFf; i0 = nInact;
      actAxisEn = VEC[k].en;
      raw(VEC[k].x, VEC[k].y, VEC[k].z);
      chk($sformatf("R1/R2/R7 vec%0d act", k), nAct - a0, int'(VEC[k].expAct));
      chk($sformatf("R3/R4/R7 vec%0d ff", k), nFf - f0, int'(VEC[k].expFf));
      chk($sformatf("R5 vec%0d inact", k), nInact - i0, 0);
    end
    actAxisEn = 3'b111;

    // R1 / R8 exact latency
    raw(8'd0, 8'd0, 8'd0);
    rawMag = {8'd0, 8'd0, 8'd150}; rawValid = 1'b1; step(1); rawValid = 1'b0;
    step(1); chk("R1 not early", int'(actPulse), 0);
    step(1); chk("R1 on time", int'(actPulse), 1);
    step(1); chk("R8 one cycle", int'(actPulse), 0);
    step(2);

    // R3 timed free-fall
    ffTime = 8'd4;
    raw(8'd50, 8'd0, 8'd0);
    f0 = nFf;
    raw(8'd1, 8'd1, 8'd1);
    repeat (3) tickFf();
    chk("R3 before dwell", nFf - f0, 0);
    tickFf();
    chk("R3 dwell reached", nFf - f0, 1);
    repeat (3) tickFf();
    chk("R7 ff no refire", nFf - f0, 1);

    // R4 breaking sample restarts count
    raw(8'd50, 8'd0, 8'd0);
    f0 = nFf;
    raw(8'd1, 8'd1, 8'd1);
    repeat (3) tickFf();
    raw(8'd1, 8'd10, 8'd1);
    raw(8'd1, 8'd1, 8'd1);
    repeat (3) tickFf();
    chk("R4 count cleared", nFf - f0, 0);
    tickFf();
    chk("R4 fires after fresh dwell", nFf - f0, 1);

    // R5 stream separation
    i0 = nInact; a0 = nAct;
    raw(8'd0, 8'd0, 8'd0);
    chk("R5 raw ignored by inact", nInact - i0, 0);
    filt(8'd200, 8'd200, 8'd200);
    chk("R5 filt ignored by act", nAct - a0, 0);

    // R6 zero time, R7 episode
    i0 = nInact;
    filt(8'd5, 8'd5, 8'd5);
    chk("R6 zero time fires", nInact - i0, 1);
    filt(8'd4, 8'd4, 8'd4);
    chk("R7 inact no refire", nInact - i0, 1);
    filt(8'd30, 8'd0, 8'd0);
    filt(8'd19, 8'd0, 8'd0);
    chk("R7 inact rearmed", nInact - i0, 2);

    // R6 timed inactivity
    inactTime = 8'd2;
    filt(8'd30, 8'd0, 8'd0);
    i0 = nInact;
    filt(8'd0, 8'd0, 8'd0);
    tickSec();
    chk("R6 before seconds", nInact - i0, 0);
    tickSec();
    chk("R6 seconds reached", nInact - i0, 1);

    // R2 disabled Z ignored by inactivity
    inactTime = 8'd0; inactAxisEn = 3'b011;
    filt(8'd30, 8'd0, 8'd0);
    i0 = nInact;
    filt(8'd5, 8'd5, 8'd200);
    chk("R2 inact disabled axis", nInact - i0, 1);

    // R10 no enabled axis
    inactAxisEn = 3'b000;
    i0 = nInact;
    filt(8'd0, 8'd0, 8'd0);
    chk("R10 no axes", nInact - i0, 0);

    // R10 no filtered sample yet
    inactAxisEn = 3'b111;
    doReset();
    i0 = nInact;
    repeat (4) tickSec();
    raw(8'd0, 8'd0, 8'd0);
    chk("R10 needs filtered sample", nInact - i0, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5 * 100000);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule